// File: doc/BRIEF.md
# GCR Flux Read/Write Separator

This block sits between a floppy head's digitised flux stream and a byte-wide controller. Each clock is one sample period. A one on `flux_i` marks a magnetic transition. The block rebuilds the bit-cell timing from these transitions. A two-bit density value presets a sixteen-step cycle counter, so the cell length is `16 - dens_i` clocks. From the cell timing the block recovers serial data bits, which it shifts into a ten-bit register. In read mode it reports a sync mark when that register holds ten ones. After sync it frames the following bits into ten-bit groups. A one-cycle low strobe marks the end of each group. An error flag shows when the register does not hold two legal five-bit codes.

In write mode the same cell timing clocks a serializer. At each group boundary the byte on `byte_i` is split into two nibbles. Each nibble is converted by a built-in 4-to-5 group code table. The resulting ten bits are sent most significant first on `wr_bit_o`. A mode input can instead select an all-ones group, which writes a sync mark.

Top module: `gcr_separator`

## Requirements
- R1: While `rst_n` is low, `ready_n_o` and `sync_n_o` read 1, and `err_o`, `wr_bit_o` and `shreg_o` read 0.
- R2: A transition loads the cycle counter with `dens_i` and clears the four-bit cell counter. Otherwise the cycle counter counts up. On reaching 16 it reloads `dens_i` and the cell counter advances modulo 16. One cell therefore lasts `16 - dens_i` clocks at every density.
- R3: A bit is taken when cell-counter bit 1 rises. The bit is 1 only if cell-counter bits 3 and 2 are both 0, so it is 1 when a transition arrives two cells earlier and 0 on each later four-cell step. The bit enters `shreg_o` at bit 0, and older bits move toward bit 9.
- R4: `sync_n_o` is low exactly when read mode (`rd_mode_i` = 1) is selected and `shreg_o` is 10'h3FF. It never goes low in write mode.
- R5: While sync is low, the group bit counter stays at 0 and no `ready_n_o` strobe occurs.
- R6: After sync releases, the first data bit (the bit that released it) is not counted. The count then runs 0 to 9 and wraps. `ready_n_o` is low for one clock at the fall of cell-counter bit 1 that follows the tenth data bit, and `shreg_o` then holds the whole group. Back-to-back groups give one strobe each.
- R7: At each strobe the write register loads a group. With `gcr_mode_i` = 1 the group is {code(byte[7:4]), code(byte[3:0])}. The code table maps 0..F to 01010, 01011, 10010, 10011, 01110, 01111, 10110, 10111, 01001, 11001, 11010, 11011, 01101, 11101, 11110, 10101. With `gcr_mode_i` = 0 the group is all ones.
- R8: In write mode, `wr_bit_o` takes write-register bit 9 at each bit-sample instant. The register shifts left at each fall of cell-counter bit 1, so a loaded group appears bit 9 first, one bit every four cells. In read mode `wr_bit_o` is 0.
- R9: `err_o` is high when `ready_n_o` is inactive and, in read mode, either half of the register is not one of the sixteen codes in R7. It is low during a strobe and always low in write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one flux sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| flux_i | input | 1 | Flux transition seen in this sample period |
| dens_i | input | 2 | Density preset for the cycle counter |
| rd_mode_i | input | 1 | 1 = read, 0 = write |
| gcr_mode_i | input | 1 | Write group source: 1 = coded byte, 0 = sync ones |
| byte_i | input | 8 | Byte to encode in write mode |
| wr_bit_o | output | 1 | Serial bit toward the head |
| ready_n_o | output | 1 | Active-low group-boundary strobe |
| sync_n_o | output | 1 | Active-low sync mark flag |
| err_o | output | 1 | Invalid code flag |
| shreg_o | output | 10 | Recovered read shift register |

## Verification
Two events can fall in the same cycle: the group-boundary strobe, and a flux transition that restarts the cell counter. This happens because the fall of cell-counter bit 1 that closes a group is usually caused by the next transition clearing the counter. Every read stream ends with such a transition. The bench checks that the strobe still fires once and that the captured register equals the expected group. The release of sync and the first data bit also share one cycle. Here the bench judges the framing by the group seen at the next strobe, for several densities and for back-to-back groups.

// File: rtl/gcr_sep_pkg.sv
package gcr_sep_pkg;
  localparam int NIB_W   = 4;
  localparam int CODE_W  = 5;
  localparam int HALVES  = 2;
  localparam int GROUP_W = CODE_W * HALVES;
  localparam int BYTE_W  = NIB_W * HALVES;

  function automatic logic [CODE_W-1:0] gcr_enc5(input logic [NIB_W-1:0] nib);
    logic [CODE_W-1:0] c;
    case (nib)
      4'h0: c = 5'b01010;
      4'h1: c = 5'b01011;
      4'h2: c = 5'b10010;
      4'h3: c = 5'b10011;
      4'h4: c = 5'b01110;
      4'h5: c = 5'b01111;
      4'h6: c = 5'b10110;
      4'h7: c = 5'b10111;
      4'h8: c = 5'b01001;
      4'h9: c = 5'b11001;
      4'hA: c = 5'b11010;
      4'hB: c = 5'b11011;
      4'hC: c = 5'b01101;
      4'hD: c = 5'b11101;
      4'hE: c = 5'b11110;
      default: c = 5'b10101;
    endcase
    return c;
  endfunction

  // A five-bit code is legal when some nibble encodes to it.
  function automatic logic gcr_code_ok(input logic [CODE_W-1:0] code);
    logic hit;
    hit = 1'b0;
    for (int n = 0; n < (1 << NIB_W); n++) begin
      if (gcr_enc5(NIB_W'(n)) == code) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/gcr_cell_timer.sv
module gcr_cell_timer #(
  parameter int DENS_W     = 2,
  parameter int CELL_W     = 4,
  parameter int CYC_TOP    = 16,
  parameter int SAMPLE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flux_i,
  input  logic [DENS_W-1:0] dens_i,
  output logic              rise_o,
  output logic              fall_o,
  output logic              bit_val_o
);
  localparam int CYC_W = $clog2(CYC_TOP + 1);

  logic [CYC_W-1:0]  cyc_q, cyc_d, cyc_inc, dens_ext;
  logic [CELL_W-1:0] cell_q, cell_d;

  assign dens_ext = CYC_W'(dens_i);
  assign cyc_inc  = cyc_q + 1'b1;

  always_comb begin
    cyc_d  = cyc_inc;
    cell_d = cell_q;
    if (flux_i) begin
      cyc_d  = dens_ext;
      cell_d = '0;
    end else if (cyc_inc == CYC_W'(CYC_TOP)) begin
      cyc_d  = dens_ext;
      cell_d = cell_q + 1'b1;
    end
  end

  assign rise_o    = ~cell_q[SAMPLE_BIT] &  cell_d[SAMPLE_BIT];
  assign fall_o    =  cell_q[SAMPLE_BIT] & ~cell_d[SAMPLE_BIT];
  assign bit_val_o = ~|cell_d[CELL_W-1:CELL_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      cell_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      cell_q <= cell_d;
    end
  end
endmodule

// File: rtl/gcr_read_path.sv
module gcr_read_path
  import gcr_sep_pkg::*;
#(
  parameter int CNT_W = $clog2(GROUP_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_i,
  input  logic               bit_val_i,
  input  logic               rd_mode_i,
  output logic [GROUP_W-1:0] shreg_d_o,
  output logic [GROUP_W-1:0] shreg_q_o,
  output logic               sync_n_q_o,
  output logic [CNT_W-1:0]   bitcnt_d_o
);
  logic [GROUP_W-1:0] shreg_q, shreg_d;
  logic               sync_n_q, sync_n_d;
  logic [CNT_W-1:0]   bitcnt_q, bitcnt_d;

  always_comb begin
    shreg_d = shreg_q;
    if (rise_i) shreg_d = {shreg_q[GROUP_W-2:0], bit_val_i};
  end

  assign sync_n_d = ~(rd_mode_i & (&shreg_d));

  always_comb begin
    bitcnt_d = bitcnt_q;
    if (!sync_n_d) begin
      bitcnt_d = '0;
    end else if (rise_i && sync_n_q) begin
      if (bitcnt_q == CNT_W'(GROUP_W - 1)) bitcnt_d = '0;
      else                                 bitcnt_d = bitcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      sync_n_q <= 1'b1;
      bitcnt_q <= '0;
    end else begin
      shreg_q  <= shreg_d;
      sync_n_q <= sync_n_d;
      bitcnt_q <= bitcnt_d;
    end
  end

  assign shreg_d_o  = shreg_d;
  assign shreg_q_o  = shreg_q;
  assign sync_n_q_o = sync_n_q;
  assign bitcnt_d_o = bitcnt_d;
endmodule

// File: rtl/gcr_write_path.sv
module gcr_write_path
  import gcr_sep_pkg::*;
#(
  parameter int CNT_W = $clog2(GROUP_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic [CNT_W-1:0]   bitcnt_d_i,
  input  logic               rd_mode_i,
  input  logic               gcr_mode_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic [GROUP_W-1:0] shreg_d_i,
  output logic               ready_n_o,
  output logic               err_o,
  output logic               wr_bit_o
);
  logic [GROUP_W-1:0] coded, group_sel;
  logic [HALVES-1:0]  half_ok;
  logic [GROUP_W-1:0] wsh_q, wsh_d;
  logic               ready_n_q, ready_n_d;
  logic               err_q, err_d;
  logic               wr_q, wr_d;
  logic               load, valid;

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    assign coded[g*CODE_W +: CODE_W] = gcr_enc5(byte_i[g*NIB_W +: NIB_W]);
    assign half_ok[g]                = gcr_code_ok(shreg_d_i[g*CODE_W +: CODE_W]);
  end

  assign group_sel = gcr_mode_i ? coded : '1;
  assign load      = fall_i & (bitcnt_d_i == CNT_W'(GROUP_W - 1));
  assign ready_n_d = ~load;
  assign valid     = rd_mode_i ? (&half_ok) : 1'b1;
  assign err_d     = ~valid & ready_n_d;

  always_comb begin
    wsh_d = wsh_q;
    if (load)        wsh_d = group_sel;
    else if (fall_i) wsh_d = {wsh_q[GROUP_W-2:0], 1'b0};
  end

  always_comb begin
    wr_d = wr_q;
    if (rd_mode_i)   wr_d = 1'b0;
    else if (rise_i) wr_d = wsh_q[GROUP_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsh_q     <= '0;
      ready_n_q <= 1'b1;
      err_q     <= 1'b0;
      wr_q      <= 1'b0;
    end else begin
      wsh_q     <= wsh_d;
      ready_n_q <= ready_n_d;
      err_q     <= err_d;
      wr_q      <= wr_d;
    end
  end

  assign ready_n_o = ready_n_q;
  assign err_o     = err_q;
  assign wr_bit_o  = wr_q;
endmodule

// File: rtl/gcr_separator.sv
module gcr_separator
  import gcr_sep_pkg::*;
#(
  parameter int DENS_W  = 2,
  parameter int CELL_W  = 4,
  parameter int CYC_TOP = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flux_i,
  input  logic [DENS_W-1:0]  dens_i,
  input  logic               rd_mode_i,
  input  logic               gcr_mode_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic               wr_bit_o,
  output logic               ready_n_o,
  output logic               sync_n_o,
  output logic               err_o,
  output logic [GROUP_W-1:0] shreg_o
);
  localparam int CNT_W = $clog2(GROUP_W);

  logic               rise, fall, bit_val;
  logic [GROUP_W-1:0] shreg_d;
  logic [CNT_W-1:0]   bitcnt_d;

  gcr_cell_timer #(
    .DENS_W(DENS_W), .CELL_W(CELL_W), .CYC_TOP(CYC_TOP), .SAMPLE_BIT(1)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .flux_i(flux_i), .dens_i(dens_i),
    .rise_o(rise), .fall_o(fall), .bit_val_o(bit_val)
  );

  gcr_read_path #(.CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .bit_val_i(bit_val),
    .rd_mode_i(rd_mode_i), .shreg_d_o(shreg_d), .shreg_q_o(shreg_o),
    .sync_n_q_o(sync_n_o), .bitcnt_d_o(bitcnt_d)
  );

  gcr_write_path #(.CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
    .bitcnt_d_i(bitcnt_d), .rd_mode_i(rd_mode_i), .gcr_mode_i(gcr_mode_i),
    .byte_i(byte_i), .shreg_d_i(shreg_d), .ready_n_o(ready_n_o),
    .err_o(err_o), .wr_bit_o(wr_bit_o)
  );
endmodule

// File: rtl/gcr_separator_chk.sv
module gcr_separator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_mode_i,
  input logic       wr_bit_o,
  input logic       ready_n_o,
  input logic       sync_n_o,
  input logic       err_o,
  input logic [9:0] shreg_o
);
  // R6
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n_o |=> ready_n_o);

  // R4
  sync_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_o |-> (shreg_o == 10'h3FF));

  // R4
  sync_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_o |-> $past(rd_mode_i));

  // R5
  sync_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_o |-> ready_n_o);

  // R9
  err_quiet_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n_o |-> !err_o);

  // R9
  err_write_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_mode_i) |-> !err_o);

  // R8
  wr_read_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_mode_i) |-> !wr_bit_o);
endmodule

bind gcr_separator gcr_separator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_mode_i(rd_mode_i), .wr_bit_o(wr_bit_o),
  .ready_n_o(ready_n_o), .sync_n_o(sync_n_o), .err_o(err_o), .shreg_o(shreg_o)
);

// File: tb/gcr_separator_tb_top.sv
`timescale 1ns/1ps
module gcr_separator_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flux_i = 1'b0;
  logic [1:0] dens_i = 2'd0;
  logic       rd_mode_i = 1'b1;
  logic       gcr_mode_i = 1'b1;
  logic [7:0] byte_i = 8'h00;
  logic       wr_bit_o, ready_n_o, sync_n_o, err_o;
  logic [9:0] shreg_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // byte, density, expected ten-bit group
  localparam logic [19:0] VEC [5] = '{
    {8'h5A, 2'd0, 10'h1FA},
    {8'h00, 2'd1, 10'h14A},
    {8'h4F, 2'd2, 10'h1D5},
    {8'h89, 2'd3, 10'h139},
    {8'hC6, 2'd0, 10'h1B6}
  };

  always #2.5 clk = ~clk;

  gcr_separator dut_i (
    .clk(clk), .rst_n(rst_n), .flux_i(flux_i), .dens_i(dens_i),
    .rd_mode_i(rd_mode_i), .gcr_mode_i(gcr_mode_i), .byte_i(byte_i),
    .wr_bit_o(wr_bit_o), .ready_n_o(ready_n_o), .sync_n_o(sync_n_o),
    .err_o(err_o), .shreg_o(shreg_o)
  );

  // strobe monitor
  int         rcnt = 0;
  logic [9:0] rlast = '0, rprev = '0;
  logic       rerr_at = 1'b0, errcap = 1'b0;
  bit         rhi = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) rhi = 1'b1;
    else begin
      if (!ready_n_o && rhi) begin
        rcnt++; rprev = rlast; rlast = shreg_o; rerr_at = err_o;
      end
      if (ready_n_o && !rhi) errcap = err_o;
      rhi = ready_n_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; flux_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse();
    flux_i = 1'b1; @(negedge clk); flux_i = 1'b0;
  endtask

  // Send a bit stream, MSB first, starting with 1, then one closing transition.
  task automatic send_stream(input logic [39:0] bits, input int n);
    int cp = 16 - int'(dens_i);
    int i  = n - 1;
    while (i >= 0) begin
      int k = 0;
      while ((i - 1 - k) >= 0 && bits[i-1-k] == 1'b0) k++;
      pulse();
      repeat ((3 + 4*k)*cp + cp/2 - 1) @(negedge clk);
      i = i - 1 - k;
    end
    pulse();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finish");
    finish_run();
  end

  initial begin
    // R1 reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ready_n_o == 1 && sync_n_o == 1 && err_o == 0 && wr_bit_o == 0 && shreg_o == 0,
          "R1 reset outputs", {ready_n_o, sync_n_o, err_o, wr_bit_o, shreg_o}, 14'h3000);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 sync detect, R5 counter held during sync
    rd_mode_i = 1'b1; dens_i = 2'd0;
    send_stream(40'h3FF, 10);
    check(sync_n_o == 0, "R4 sync low on ten ones", sync_n_o, 0);
    check(shreg_o == 10'h3FF, "R3 shreg holds ones", shreg_o, 10'h3FF);
    rcnt = 0;
    send_stream(40'h3FF, 10);
    check(rcnt == 0, "R5 no strobe during sync", rcnt, 0);
    check(sync_n_o == 0, "R5 sync still low", sync_n_o, 0);

    // vector table: read framing then write serialization per density (R2 R3 R6 R7 R8 R9)
    for (int v = 0; v < 5; v++) begin
      logic [7:0] b; logic [1:0] d; logic [9:0] code;
      int cp;
      {b, d, code} = VEC[v];
      do_reset();
      dens_i = d; rd_mode_i = 1'b1; gcr_mode_i = 1'b1; byte_i = b;
      cp = 16 - int'(d);
      rcnt = 0;
      send_stream({20'h0, 10'h3FF, code}, 20);
      check(rcnt >= 1, "R6 strobe seen", rcnt, 1);
      check(rlast == code, "R6 R2 group at strobe", rlast, code);
      check(rerr_at == 0, "R9 err low at strobe", rerr_at, 0);
      check(errcap == 0, "R9 valid group no err", errcap, 0);
      check(wr_bit_o == 0, "R8 wr low in read", wr_bit_o, 0);

      rd_mode_i = 1'b0;
      begin
        int t = 0;
        @(negedge clk);
        while (ready_n_o !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
      end
      check(ready_n_o == 0, "R6 strobe in write mode", ready_n_o, 0);
      repeat (3*cp) @(negedge clk);
      for (int j = 0; j < 10; j++) begin
        check(wr_bit_o == code[9-j], "R7 R8 serial bit", wr_bit_o, code[9-j]);
        check(err_o == 0, "R9 err low in write", err_o, 0);
        repeat (4*cp) @(negedge clk);
      end
      check(sync_n_o == 1, "R4 no sync in write", sync_n_o, 1);
    end

    // R6 back-to-back groups, R2 density 0
    do_reset();
    dens_i = 2'd0; rd_mode_i = 1'b1;
    rcnt = 0;
    send_stream({10'h0, 10'h3FF, 10'h1FA, 10'h2B5}, 30);
    check(rcnt >= 2, "R6 two strobes", rcnt, 2);
    check(rprev == 10'h1FA, "R6 first group", rprev, 10'h1FA);
    check(rlast == 10'h2B5, "R6 second group after wrap", rlast, 10'h2B5);

    // R9 invalid group raises err after the strobe
    do_reset();
    dens_i = 2'd2; rd_mode_i = 1'b1;
    send_stream({20'h0, 10'h3FF, 10'h19C}, 20);
    check(rlast == 10'h19C, "R3 invalid group captured", rlast, 10'h19C);
    check(rerr_at == 0, "R9 err low during strobe", rerr_at, 0);
    check(errcap == 1, "R9 err high on bad code", errcap, 1);

    // R7 sync-mark source in write mode
    do_reset();
    dens_i = 2'd1; rd_mode_i = 1'b0; gcr_mode_i = 1'b0; byte_i = 8'h00;
    begin
      int t = 0;
      while (ready_n_o !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    end
    repeat (3*15) @(negedge clk);
    for (int j = 0; j < 10; j++) begin
      check(wr_bit_o == 1, "R7 sync group bit", wr_bit_o, 1);
      repeat (4*15) @(negedge clk);
    end

    // R1 asynchronous reset mid-run
    @(negedge clk); #1 rst_n = 1'b0; #1;
    check(ready_n_o == 1 && sync_n_o == 1 && err_o == 0 && wr_bit_o == 0 && shreg_o == 0,
          "R1 reset mid-run", {ready_n_o, sync_n_o, err_o, wr_bit_o, shreg_o}, 14'h3000);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    finish_run();
  end
endmodule